// File: doc/BRIEF.md
# Completion Error Monitor

This block sits beside the command engine of a storage host controller. It collects every error source that the controller can meet into one 32-bit vector whose bits only ever set. The sources are the device identity check at start-up, the capability check, the logical-block size check, the flags decoded from link-layer completion packets, and the completion entries returned on the admin queue and the I/O queue. A summary flag is high whenever any bit of the vector is set. The vector and the flag clear only on reset.

The block also keeps a completion timer for each queue. The controller pulses a wait-start strobe when it issues a command. If no completion arrives on that queue within a programmable number of clock cycles, the timeout bit for that queue is set. A limit of zero turns both timers off. Each queue has a phase tracker that knows which phase value the next completion must carry. The expected phase starts at 1 and inverts each time the queue index wraps.

For diagnosis, the block keeps a capability snapshot and one status word per queue. Each of these follows its input until the matching error bit is set, then freezes so that it holds the first offending value. All inputs are single-cycle valid strobes with their fields. The monitor accepts an event on every cycle and never applies back-pressure, so there is no ready signal.

Top module: `cmpl_err_monitor`

## Requirements
- R1: While reset is held and after it is released with no event, err_vec, err_flag, adm_word, io_word and cap_snap are all 0.
- R2: A class_chk_valid strobe whose class_code differs from parameter EXP_CLASS (default 24'h010802) sets err_vec[0] at the next clock edge. A matching code sets nothing.
- R3: A cap_chk_valid strobe sets err_vec[1] when any of these holds: cap_min_page is nonzero, cap_nvm_set is 0, cap_db_stride is nonzero, or cap_max_q_ent is less than 2·2^CMD_DEPTH_LOG2−1 (63 by default). cap_snap packs the fields as max queue entries [15:0], doorbell stride [19:16], command-set flag [20], minimum page [24:21], and 0 in [31:25].
- R4: With timeout_limit = N > 0, an adm_wait_start sampled at edge E0 and no admin completion sampled at edges E1 to EN sets err_vec[2] at edge EN and not earlier.
- R5: The same rule applies to io_wait_start, the I/O completions and err_vec[4].
- R6: A timeout_limit of 0 disables both timers. A completion sampled before the limit edge cancels that queue's wait.
- R7: An admin completion sets err_vec[3] when its status field is nonzero, its phase differs from the expected phase, or adm_cpl_cid differs from adm_exp_cid. adm_word takes the status in [15:1] and, in [0], the OR of the bad-phase and bad-ID conditions.
- R8: An I/O completion sets err_vec[5] when its status is nonzero or its phase is wrong. io_word takes the phase-bad flag in [0], the status in [15:1], the command ID in [23:16], and 0 in [31:24].
- R9: On each queue the expected phase is 1 after reset and inverts after every ADM_Q_DEPTH (admin) or 2^CMD_DEPTH_LOG2 (I/O) completions.
- R10: pkt_len_err, pkt_ecc_err, pkt_unsup_req and pkt_cpl_abort set err_vec bits 6, 7, 8 and 9. A lba_chk_valid strobe with lba_size_log2 ≠ 9 sets err_vec[16].
- R11: err_flag equals (err_vec ≠ 0). Set bits are never cleared except by reset, and bits 10 to 15 and 17 to 31 stay 0.
- R12: cap_snap, adm_word and io_word update on every strobe of their source while err_vec bit 1, 3 or 5 (respectively) is clear, and hold their value once that bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| timeout_limit | input | 32 | Completion wait limit in clock cycles, 0 = off |
| class_chk_valid | input | 1 | Strobe: class code available |
| class_code | input | 24 | Device class code |
| cap_chk_valid | input | 1 | Strobe: capability fields available |
| cap_max_q_ent | input | 16 | Maximum queue entries supported |
| cap_db_stride | input | 4 | Doorbell stride |
| cap_nvm_set | input | 1 | Command-set supported flag |
| cap_min_page | input | 4 | Minimum memory page size code |
| lba_chk_valid | input | 1 | Strobe: block size available |
| lba_size_log2 | input | 8 | Logical block size as power of two |
| pkt_len_err | input | 1 | Strobe: completion packet size wrong |
| pkt_ecc_err | input | 1 | Strobe: buffer ECC error |
| pkt_unsup_req | input | 1 | Strobe: unsupported-request completion |
| pkt_cpl_abort | input | 1 | Strobe: completer-abort completion |
| adm_wait_start | input | 1 | Admin command issued, start timer |
| adm_cpl_valid | input | 1 | Admin completion strobe |
| adm_cpl_status | input | 15 | Admin completion status field |
| adm_cpl_phase | input | 1 | Admin completion phase tag |
| adm_cpl_cid | input | 16 | Admin completion command ID |
| adm_exp_cid | input | 16 | Expected admin command ID |
| io_wait_start | input | 1 | I/O command issued, start timer |
| io_cpl_valid | input | 1 | I/O completion strobe |
| io_cpl_status | input | 15 | I/O completion status field |
| io_cpl_phase | input | 1 | I/O completion phase tag |
| io_cpl_cid | input | 8 | I/O completion command ID |
| err_vec | output | 32 | Sticky error vector |
| err_flag | output | 1 | High when err_vec is nonzero |
| adm_word | output | 16 | Captured admin status word |
| io_word | output | 32 | Captured I/O status word |
| cap_snap | output | 32 | Captured capability fields |

## Verification
Every error bit, the flag, the status words and the snapshot change at the first clock edge that samples the causing strobe. The bench drives each strobe on a falling edge, lets one rising edge pass, and compares on the next falling edge. Timeouts are due at exactly the N-th edge after the edge that samples the start strobe. The bench counts N−1 edges and checks that the bit is still clear, then counts one more edge and checks that it is set. Phase-wrap and freeze cases are checked on the falling edge after each completion in a sequence.

// File: rtl/cmpl_err_pkg.sv
`timescale 1ns/1ps
package cmpl_err_pkg;
  localparam int ERR_W       = 32;
  localparam int B_CLASS     = 0;
  localparam int B_CAP       = 1;
  localparam int B_ADM_TO    = 2;
  localparam int B_ADM_STAT  = 3;
  localparam int B_IO_TO     = 4;
  localparam int B_IO_STAT   = 5;
  localparam int B_PKT_BASE  = 6;
  localparam int PKT_FLAGS   = 4;
  localparam int B_LBA       = 16;
  localparam logic [ERR_W-1:0] USED_MASK = 32'h0001_03FF;
  localparam logic [7:0] LBA_LOG2_OK = 8'd9;
endpackage

// File: rtl/cmpl_wait_timer.sv
`timescale 1ns/1ps
module cmpl_wait_timer #(
  parameter int TIMER_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TIMER_W-1:0] limit,
  input  logic               start,
  input  logic               stop,
  output logic               fire
);
  logic               waiting;
  logic [TIMER_W-1:0] cnt;

  // Fires on the edge where the limit-th cycle of waiting ends.
  assign fire = waiting && !start && !stop && (limit != '0) &&
                (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      waiting <= 1'b1;
      cnt     <= '0;
    end else if (stop || fire) begin
      waiting <= 1'b0;
      cnt     <= '0;
    end else if (waiting) begin
      cnt     <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cmpl_phase_track.sv
`timescale 1ns/1ps
module cmpl_phase_track #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpl_valid,
  input  logic cpl_phase,
  output logic phase_bad
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] idx;
  logic             exp_phase;

  assign phase_bad = cpl_valid && (cpl_phase != exp_phase);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx       <= '0;
      exp_phase <= 1'b1;
    end else if (cpl_valid) begin
      if (idx == LAST) begin
        idx       <= '0;
        exp_phase <= ~exp_phase;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmpl_cap_check.sv
`timescale 1ns/1ps
module cmpl_cap_check #(
  parameter int CMD_DEPTH_LOG2 = 5
) (
  input  logic [15:0] max_q_ent,
  input  logic [3:0]  db_stride,
  input  logic        nvm_set,
  input  logic [3:0]  min_page,
  output logic        cap_fail,
  output logic [31:0] snap
);
  localparam int CMD_DEPTH = 1 << CMD_DEPTH_LOG2;
  localparam logic [15:0] MIN_Q_ENT = 16'(2 * CMD_DEPTH - 1);

  assign cap_fail = (min_page != 4'd0) || !nvm_set ||
                    (db_stride != 4'd0) || (max_q_ent < MIN_Q_ENT);
  assign snap = {7'd0, min_page, nvm_set, db_stride, max_q_ent};
endmodule

// File: rtl/cmpl_err_monitor.sv
`timescale 1ns/1ps
module cmpl_err_monitor
  import cmpl_err_pkg::*;
#(
  parameter int          CMD_DEPTH_LOG2 = 5,
  parameter int          ADM_Q_DEPTH    = 4,
  parameter int          TIMER_W        = 32,
  parameter logic [23:0] EXP_CLASS      = 24'h010802
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] timeout_limit,
  input  logic        class_chk_valid,
  input  logic [23:0] class_code,
  input  logic        cap_chk_valid,
  input  logic [15:0] cap_max_q_ent,
  input  logic [3:0]  cap_db_stride,
  input  logic        cap_nvm_set,
  input  logic [3:0]  cap_min_page,
  input  logic        lba_chk_valid,
  input  logic [7:0]  lba_size_log2,
  input  logic        pkt_len_err,
  input  logic        pkt_ecc_err,
  input  logic        pkt_unsup_req,
  input  logic        pkt_cpl_abort,
  input  logic        adm_wait_start,
  input  logic        adm_cpl_valid,
  input  logic [14:0] adm_cpl_status,
  input  logic        adm_cpl_phase,
  input  logic [15:0] adm_cpl_cid,
  input  logic [15:0] adm_exp_cid,
  input  logic        io_wait_start,
  input  logic        io_cpl_valid,
  input  logic [14:0] io_cpl_status,
  input  logic        io_cpl_phase,
  input  logic [7:0]  io_cpl_cid,
  output logic [31:0] err_vec,
  output logic        err_flag,
  output logic [15:0] adm_word,
  output logic [31:0] io_word,
  output logic [31:0] cap_snap
);
  localparam int IO_Q_DEPTH = 1 << CMD_DEPTH_LOG2;

  logic        adm_fire, io_fire;
  logic        adm_ph_bad, io_ph_bad;
  logic        cap_fail;
  logic [31:0] cap_pack;
  logic        adm_id_bad, adm_bad, io_bad;
  logic [PKT_FLAGS-1:0] pkt_flags;
  logic [ERR_W-1:0]     set_vec, vec_nxt;

  cmpl_wait_timer #(.TIMER_W(TIMER_W)) u_adm_tmr (
    .clk(clk), .rst_n(rst_n), .limit(TIMER_W'(timeout_limit)),
    .start(adm_wait_start), .stop(adm_cpl_valid), .fire(adm_fire));

  cmpl_wait_timer #(.TIMER_W(TIMER_W)) u_io_tmr (
    .clk(clk), .rst_n(rst_n), .limit(TIMER_W'(timeout_limit)),
    .start(io_wait_start), .stop(io_cpl_valid), .fire(io_fire));

  cmpl_phase_track #(.DEPTH(ADM_Q_DEPTH)) u_adm_ph (
    .clk(clk), .rst_n(rst_n), .cpl_valid(adm_cpl_valid),
    .cpl_phase(adm_cpl_phase), .phase_bad(adm_ph_bad));

  cmpl_phase_track #(.DEPTH(IO_Q_DEPTH)) u_io_ph (
    .clk(clk), .rst_n(rst_n), .cpl_valid(io_cpl_valid),
    .cpl_phase(io_cpl_phase), .phase_bad(io_ph_bad));

  cmpl_cap_check #(.CMD_DEPTH_LOG2(CMD_DEPTH_LOG2)) u_cap (
    .max_q_ent(cap_max_q_ent), .db_stride(cap_db_stride),
    .nvm_set(cap_nvm_set), .min_page(cap_min_page),
    .cap_fail(cap_fail), .snap(cap_pack));

  assign adm_id_bad = adm_cpl_valid && (adm_cpl_cid != adm_exp_cid);
  assign adm_bad    = adm_cpl_valid &&
                      ((adm_cpl_status != '0) || adm_ph_bad || adm_id_bad);
  assign io_bad     = io_cpl_valid && ((io_cpl_status != '0) || io_ph_bad);
  assign pkt_flags  = {pkt_cpl_abort, pkt_unsup_req, pkt_ecc_err, pkt_len_err};

  always_comb begin
    set_vec             = '0;
    set_vec[B_CLASS]    = class_chk_valid && (class_code != EXP_CLASS);
    set_vec[B_CAP]      = cap_chk_valid && cap_fail;
    set_vec[B_ADM_TO]   = adm_fire;
    set_vec[B_ADM_STAT] = adm_bad;
    set_vec[B_IO_TO]    = io_fire;
    set_vec[B_IO_STAT]  = io_bad;
    set_vec[B_LBA]      = lba_chk_valid && (lba_size_log2 != LBA_LOG2_OK);
    for (int i = 0; i < PKT_FLAGS; i++) begin
      set_vec[B_PKT_BASE + i] = pkt_flags[i];
    end
  end

  assign vec_nxt = err_vec | set_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_vec  <= '0;
      err_flag <= 1'b0;
    end else begin
      err_vec  <= vec_nxt;
      err_flag <= |vec_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adm_word <= '0;
      io_word  <= '0;
      cap_snap <= '0;
    end else begin
      if (adm_cpl_valid && !err_vec[B_ADM_STAT])
        adm_word <= {adm_cpl_status, adm_ph_bad | adm_id_bad};
      if (io_cpl_valid && !err_vec[B_IO_STAT])
        io_word <= {8'd0, io_cpl_cid, io_cpl_status, io_ph_bad};
      if (cap_chk_valid && !err_vec[B_CAP])
        cap_snap <= cap_pack;
    end
  end
endmodule

// File: rtl/cmpl_err_monitor_chk.sv
`timescale 1ns/1ps
module cmpl_err_monitor_chk
  import cmpl_err_pkg::*;
#(
  parameter logic [23:0] EXP_CLASS = 24'h010802
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] timeout_limit,
  input logic        class_chk_valid,
  input logic [23:0] class_code,
  input logic [31:0] err_vec,
  input logic        err_flag,
  input logic [15:0] adm_word,
  input logic [31:0] io_word,
  input logic [31:0] cap_snap
);
  p_flag_tracks_vec_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag == (err_vec != '0));

  p_bits_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_vec & $past(err_vec)) == $past(err_vec));

  p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_vec & ~USED_MASK) == '0);

  p_io_word_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
    io_word[31:24] == 8'd0);

  p_class_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (class_chk_valid && class_code != EXP_CLASS) |=> err_vec[B_CLASS]);

  p_timeout_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(err_vec[B_ADM_TO]) || $rose(err_vec[B_IO_TO])) |->
      ($past(timeout_limit) != '0));

  p_cap_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_vec[B_CAP]) |-> $stable(cap_snap));

  p_adm_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_vec[B_ADM_STAT]) |-> $stable(adm_word));
endmodule

bind cmpl_err_monitor cmpl_err_monitor_chk #(.EXP_CLASS(EXP_CLASS)) u_chk (
  .clk(clk), .rst_n(rst_n), .timeout_limit(timeout_limit),
  .class_chk_valid(class_chk_valid), .class_code(class_code),
  .err_vec(err_vec), .err_flag(err_flag), .adm_word(adm_word),
  .io_word(io_word), .cap_snap(cap_snap));

// File: tb/cmpl_err_monitor_tb.sv
`timescale 1ns/1ps
module cmpl_err_monitor_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] timeout_limit;
  logic        class_chk_valid;
  logic [23:0] class_code;
  logic        cap_chk_valid;
  logic [15:0] cap_max_q_ent;
  logic [3:0]  cap_db_stride;
  logic        cap_nvm_set;
  logic [3:0]  cap_min_page;
  logic        lba_chk_valid;
  logic [7:0]  lba_size_log2;
  logic        pkt_len_err, pkt_ecc_err, pkt_unsup_req, pkt_cpl_abort;
  logic        adm_wait_start, adm_cpl_valid, adm_cpl_phase;
  logic [14:0] adm_cpl_status;
  logic [15:0] adm_cpl_cid, adm_exp_cid;
  logic        io_wait_start, io_cpl_valid, io_cpl_phase;
  logic [14:0] io_cpl_status;
  logic [7:0]  io_cpl_cid;
  logic [31:0] err_vec;
  logic        err_flag;
  logic [15:0] adm_word;
  logic [31:0] io_word;
  logic [31:0] cap_snap;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  cmpl_err_monitor u_dut (.*);

  localparam logic [3:0] K_CLASS = 4'd0, K_CAP = 4'd1, K_LBA = 4'd2,
                         K_PKT = 4'd3, K_ADM = 4'd4, K_IO = 4'd5;

  typedef struct packed {
    logic [3:0]  kind;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] exp_vec;
    logic [31:0] exp_word;
  } row_t;

  // ADM b = {phase at bit16, cid}; IO b = {phase at bit16, cid[7:0]}.
  localparam row_t ROWS [0:19] = '{
    '{K_CLASS, 32'h0001_0802, 32'h0, 32'h0,        32'h0},
    '{K_CLASS, 32'h0001_0801, 32'h0, 32'h1,        32'h0},
    '{K_CAP,   32'h0010_003F, 32'h0, 32'h0,        32'h0010_003F},
    '{K_CAP,   32'h0010_003E, 32'h0, 32'h2,        32'h0010_003E},
    '{K_CAP,   32'h0000_003F, 32'h0, 32'h2,        32'h0000_003F},
    '{K_CAP,   32'h0011_003F, 32'h0, 32'h2,        32'h0011_003F},
    '{K_CAP,   32'h0030_003F, 32'h0, 32'h2,        32'h0030_003F},
    '{K_LBA,   32'd9,         32'h0, 32'h0,        32'h0},
    '{K_LBA,   32'd12,        32'h0, 32'h0001_0000, 32'h0},
    '{K_PKT,   32'h1,         32'h0, 32'h40,       32'h0},
    '{K_PKT,   32'h2,         32'h0, 32'h80,       32'h0},
    '{K_PKT,   32'h4,         32'h0, 32'h100,      32'h0},
    '{K_PKT,   32'h8,         32'h0, 32'h200,      32'h0},
    '{K_ADM,   32'h0,         32'h0001_00A5, 32'h0, 32'h0},
    '{K_ADM,   32'h5,         32'h0001_00A5, 32'h8, 32'h000A},
    '{K_ADM,   32'h0,         32'h0000_00A5, 32'h8, 32'h0001},
    '{K_ADM,   32'h0,         32'h0001_00A6, 32'h8, 32'h0001},
    '{K_IO,    32'h0,         32'h0001_0011, 32'h0, 32'h0011_0000},
    '{K_IO,    32'h3,         32'h0001_0022, 32'h20, 32'h0022_0006},
    '{K_IO,    32'h0,         32'h0000_0033, 32'h20, 32'h0033_0001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    class_chk_valid = 0; cap_chk_valid = 0; lba_chk_valid = 0;
    pkt_len_err = 0; pkt_ecc_err = 0; pkt_unsup_req = 0; pkt_cpl_abort = 0;
    adm_wait_start = 0; adm_cpl_valid = 0; io_wait_start = 0; io_cpl_valid = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 0;
    step(); step();
    rst_n = 1;
  endtask

  task automatic adm_cpl(input logic [14:0] st, input logic ph, input logic [15:0] cid);
    adm_cpl_valid = 1; adm_cpl_status = st; adm_cpl_phase = ph; adm_cpl_cid = cid;
    step();
    adm_cpl_valid = 0;
  endtask

  initial begin
    timeout_limit = 0; class_code = 0; cap_max_q_ent = 0; cap_db_stride = 0;
    cap_nvm_set = 0; cap_min_page = 0; lba_size_log2 = 0;
    adm_cpl_status = 0; adm_cpl_phase = 0; adm_cpl_cid = 0; adm_exp_cid = 16'h00A5;
    io_cpl_status = 0; io_cpl_phase = 0; io_cpl_cid = 0;
    @(negedge clk);
    do_reset();

    // R1: reset state
    chk("R1 err_vec", err_vec, 0);
    chk("R1 err_flag", {31'd0, err_flag}, 0);
    chk("R1 adm_word", {16'd0, adm_word}, 0);
    chk("R1 io_word", io_word, 0);
    chk("R1 cap_snap", cap_snap, 0);

    // Table: R2 R3 R7 R8 R10 R11
    for (int i = 0; i < 20; i++) begin
      do_reset();
      case (ROWS[i].kind)
        K_CLASS: begin class_chk_valid = 1; class_code = ROWS[i].a[23:0]; end
        K_CAP: begin
          cap_chk_valid = 1; cap_max_q_ent = ROWS[i].a[15:0];
          cap_db_stride = ROWS[i].a[19:16]; cap_nvm_set = ROWS[i].a[20];
          cap_min_page = ROWS[i].a[24:21];
        end
        K_LBA: begin lba_chk_valid = 1; lba_size_log2 = ROWS[i].a[7:0]; end
        K_PKT: begin
          pkt_len_err = ROWS[i].a[0]; pkt_ecc_err = ROWS[i].a[1];
          pkt_unsup_req = ROWS[i].a[2]; pkt_cpl_abort = ROWS[i].a[3];
        end
        K_ADM: begin
          adm_cpl_valid = 1; adm_cpl_status = ROWS[i].a[14:0];
          adm_cpl_phase = ROWS[i].b[16]; adm_cpl_cid = ROWS[i].b[15:0];
        end
        default: begin
          io_cpl_valid = 1; io_cpl_status = ROWS[i].a[14:0];
          io_cpl_phase = ROWS[i].b[16]; io_cpl_cid = ROWS[i].b[7:0];
        end
      endcase
      step();
      idle_inputs();
      chk($sformatf("R2/R3/R7/R8/R10 row %0d err_vec", i), err_vec, ROWS[i].exp_vec);
      chk($sformatf("R11 row %0d err_flag", i), {31'd0, err_flag},
          {31'd0, ROWS[i].exp_vec != 0});
      if (ROWS[i].kind == K_CAP)
        chk($sformatf("R3 row %0d cap_snap", i), cap_snap, ROWS[i].exp_word);
      else if (ROWS[i].kind == K_ADM)
        chk($sformatf("R7 row %0d adm_word", i), {16'd0, adm_word}, ROWS[i].exp_word);
      else if (ROWS[i].kind == K_IO)
        chk($sformatf("R8 row %0d io_word", i), io_word, ROWS[i].exp_word);
    end

    // R4: admin timeout due exactly at edge 5
    do_reset();
    timeout_limit = 5;
    adm_wait_start = 1; step(); adm_wait_start = 0;
    for (int k = 0; k < 4; k++) step();
    chk("R4 before limit", err_vec, 0);
    step();
    chk("R4 at limit", err_vec, 32'h4);
    chk("R4 flag", {31'd0, err_flag}, 1);

    // R5: I/O timeout due at edge 3
    do_reset();
    timeout_limit = 3;
    io_wait_start = 1; step(); io_wait_start = 0;
    step(); step();
    chk("R5 before limit", err_vec, 0);
    step();
    chk("R5 at limit", err_vec, 32'h10);

    // R6: completion cancels wait
    do_reset();
    timeout_limit = 5;
    io_wait_start = 1; step(); io_wait_start = 0;
    step(); step();
    io_cpl_valid = 1; io_cpl_status = 0; io_cpl_phase = 1; io_cpl_cid = 8'h07;
    step(); io_cpl_valid = 0;
    for (int k = 0; k < 10; k++) step();
    chk("R6 cancelled", err_vec, 0);

    // R6: limit 0 disables
    do_reset();
    timeout_limit = 0;
    adm_wait_start = 1; io_wait_start = 1; step();
    adm_wait_start = 0; io_wait_start = 0;
    for (int k = 0; k < 50; k++) step();
    chk("R6 disabled", err_vec, 0);

    // R9: admin phase inverts after 4 completions
    do_reset();
    for (int k = 0; k < 4; k++) adm_cpl(0, 1, 16'h00A5);
    chk("R9 first lap", err_vec, 0);
    adm_cpl(0, 0, 16'h00A5);
    chk("R9 flipped phase accepted", err_vec, 0);
    adm_cpl(15'h0, 1, 16'h00A5);
    chk("R9 stale phase rejected", err_vec, 32'h8);
    chk("R9 adm_word", {16'd0, adm_word}, 32'h1);

    // R12 and R11: freeze after error, sticky under good events
    adm_cpl(0, 0, 16'h00A5);
    chk("R12 adm_word frozen", {16'd0, adm_word}, 32'h1);
    chk("R11 sticky", err_vec, 32'h8);
    cap_chk_valid = 1; cap_max_q_ent = 16'd10; cap_db_stride = 0;
    cap_nvm_set = 1; cap_min_page = 0;
    step();
    cap_max_q_ent = 16'd100; step(); idle_inputs();
    chk("R12 cap_snap frozen", cap_snap, 32'h0010_000A);
    chk("R11 accumulate", err_vec, 32'hA);
    io_cpl_valid = 1; io_cpl_status = 15'd1; io_cpl_phase = 1; io_cpl_cid = 8'h44;
    step();
    io_cpl_status = 15'd0; io_cpl_phase = 0; io_cpl_cid = 8'h55; step();
    idle_inputs();
    chk("R12 io_word frozen", io_word, 32'h0044_0002);
    chk("R11 final vec", err_vec, 32'h2A);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule